// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. Software writes the word through a plain write strobe and can read it back at any time. The word carries a run bit, the output level to hold while stopped, an 8-bit step divisor and an 8-bit low-time count.

An internal prescaler divides the input clock by the divisor. Each of its ticks advances an 8-bit phase counter, so one output period always spans 256 phase steps. The output is low during the first part of the period, for as many steps as the low-time count gives, and high for the rest. New divisor and low-time values wait in shadow registers and take effect only when the phase counter wraps, so a period in progress is never cut short. While stopped, the pin holds the programmed rest level.

Top module: `pwm8_prescaled`

## Requirements
- R1: A synchronous active-high reset clears the whole control word to zero. While reset holds and after it, `rd_data` reads 0 and `pwm_out` is 0 until the next write.
- R2: Control word layout: bit 31 run, bit 30 rest level, bits 15:8 step divisor, bits 7:0 low-time count. Bits 29:16 always read 0 and ignore writes, so writing 32'hFFFFFFFF reads back 32'hC000FFFF.
- R3: While bit 31 is clear, `pwm_out` equals bit 30, starting in the first cycle after the write edge.
- R4: Each phase step lasts D input clocks, where D is the divisor field and a field value of 0 means D = 256. One period is 256 × D clocks.
- R5: Within a period the output is low for (low-time count) × D clocks and high for (256 − low-time count) × D clocks.
- R6: A low-time count of 0 gives an output that stays high with no low pulse while running.
- R7: Divisor and low-time values written while running take effect at the next phase wrap; the period in progress keeps its old values.
- R8: Setting bit 31 from clear restarts the prescaler and phase counter at 0. The pin holds the rest level for one cycle after the write edge, and the first period then starts with its low part.
- R9: A write that keeps bit 31 set does not restart the period in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions check on every cycle that the reserved bits read as zero, that a stopped channel drives the rest level, that the phase counter moves only on a prescaler tick and wraps only on one, that the shadow low-time value changes only at a wrap or a restart, and that a new start lands on phase 0. The exact low and high run lengths for each divisor and low-time pair, including divisor 0 and divisor 1, can only be shown by the bench's measured waveforms. The same holds for the deferred update across a period boundary, the always-high case and the one-cycle rest gap after a start.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int WORD_W = 32;
  localparam int FIELD_W = 8;
  localparam int RSVD_W = WORD_W - 2 - 2 * FIELD_W;

  typedef struct packed {
    logic                 run;
    logic                 rest_lvl;
    logic [RSVD_W-1:0]    rsvd;
    logic [FIELD_W-1:0]   divisor;
    logic [FIELD_W-1:0]   low_cnt;
  } pwm_word_t;

  // Last prescaler count value for a divisor field; 0 wraps to all ones (divide by 2**FIELD_W).
  function automatic logic [FIELD_W-1:0] step_last(input logic [FIELD_W-1:0] div);
    return div - FIELD_W'(1);
  endfunction

  // Output level for a phase position: low while phase is below the low-time count.
  function automatic logic phase_level(input logic [FIELD_W-1:0] phase,
                                       input logic [FIELD_W-1:0] low_cnt);
    return (phase < low_cnt) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/pwm8_word_reg.sv
module pwm8_word_reg
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output pwm_word_t         word_q,
  output logic [WORD_W-1:0] rd_data
);

  pwm_word_t wr_word;

  always_comb begin
    wr_word      = pwm_word_t'(wr_data);
    wr_word.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= wr_word;
    end
  end

  assign rd_data = WORD_W'(word_q);

endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
  import pwm8_pkg::*;
#(
  parameter int DIV_W = FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = step_last(divisor);
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == last) cnt_q <= '0;
      else               cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/pwm8_phase_gen.sv
module pwm8_phase_gen
  import pwm8_pkg::*;
#(
  parameter int PH_W = FIELD_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            rest_lvl,
  input  logic            tick,
  input  logic [PH_W-1:0] divisor_in,
  input  logic [PH_W-1:0] low_in,
  output logic            running,
  output logic            restart,
  output logic            wrap,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] divisor_sh,
  output logic [PH_W-1:0] low_sh,
  output logic            level
);

  localparam logic [PH_W-1:0] PH_LAST = '1;

  assign restart = enable && !running;
  assign wrap    = running && tick && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      phase      <= '0;
      divisor_sh <= '0;
      low_sh     <= '0;
    end else if (!enable) begin
      running <= 1'b0;
    end else if (restart) begin
      running    <= 1'b1;
      phase      <= '0;
      divisor_sh <= divisor_in;
      low_sh     <= low_in;
    end else if (tick) begin
      phase <= phase + PH_W'(1);
      if (wrap) begin
        divisor_sh <= divisor_in;
        low_sh     <= low_in;
      end
    end
  end

  assign level = (running && enable) ? phase_level(phase, low_sh) : rest_lvl;

endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
  import pwm8_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);

  pwm_word_t          word_q;
  logic               step_tick;
  logic               period_wrap;
  logic               chan_run;
  logic               chan_restart;
  logic [FIELD_W-1:0] phase_q;
  logic [FIELD_W-1:0] div_sh;
  logic [FIELD_W-1:0] duty_sh;

  pwm8_word_reg u_word (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .word_q  (word_q),
    .rd_data (rd_data)
  );

  pwm8_prescaler #(.DIV_W(FIELD_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .clear   (chan_restart),
    .run     (chan_run),
    .divisor (div_sh),
    .tick    (step_tick)
  );

  pwm8_phase_gen #(.PH_W(FIELD_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .enable     (word_q.run),
    .rest_lvl   (word_q.rest_lvl),
    .tick       (step_tick),
    .divisor_in (word_q.divisor),
    .low_in     (word_q.low_cnt),
    .running    (chan_run),
    .restart    (chan_restart),
    .wrap       (period_wrap),
    .phase      (phase_q),
    .divisor_sh (div_sh),
    .low_sh     (duty_sh),
    .level      (pwm_out)
  );

endmodule

// File: rtl/pwm8_prescaled_chk.sv
module pwm8_prescaled_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rd_data,
  input logic        pwm_out,
  input logic        tick,
  input logic        wrap,
  input logic        run,
  input logic [7:0]  phase,
  input logic [7:0]  sh_duty
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[29:16] == 14'd0);

  // R3
  rest_level_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[31] |-> pwm_out == rd_data[30]);

  // R4
  wrap_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> tick);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && !tick |=> $stable(phase));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && !wrap |=> $stable(sh_duty));

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[31] && !run |=> run && phase == 8'd0);

endmodule

bind pwm8_prescaled pwm8_prescaled_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_data (rd_data),
  .pwm_out (pwm_out),
  .tick    (step_tick),
  .wrap    (period_wrap),
  .run     (chan_run),
  .phase   (phase_q),
  .sh_duty (duty_sh)
);

// File: tb/sim_pwm8_prescaled.sv
`timescale 1ns/1ps
module sim_pwm8_prescaled;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm8_prescaled u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // run-length monitor
  logic prev_lvl = 1'bx;
  int   run_len = 0;
  int   last_low = 0;
  int   last_high = 0;
  int   edges = 0;

  always @(negedge clk) begin
    if (pwm_out !== prev_lvl) begin
      if (prev_lvl === 1'b0) last_low = run_len;
      if (prev_lvl === 1'b1) last_high = run_len;
      edges++;
      run_len = 1;
      prev_lvl = pwm_out;
    end else begin
      run_len++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    while (edges < n) @(posedge clk);
  endtask

  function automatic int div_of(input int r);
    return (r == 0) ? 256 : r;
  endfunction

  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{1, 1}, '{1, 255}, '{2, 128}, '{3, 64}, '{5, 200}};

  task automatic measure(input int r, input int d, input string tag);
    int e0;
    wr(32'h4000_0000);
    @(negedge clk);
    e0 = edges;
    wr({2'b11, 14'd0, 8'(r), 8'(d)});
    chk({tag, " R8 rest gap"}, pwm_out, 1);
    wait_edges(e0 + 2);
    chk({tag, " R5 low"}, last_low, d * div_of(r));
    wait_edges(e0 + 3);
    chk({tag, " R5 high"}, last_high, (256 - d) * div_of(r));
    chk({tag, " R4 period"}, last_low + last_high, 256 * div_of(r));
  endtask

  initial begin
    int e0;
    int zeros;
    repeat (3) @(negedge clk);
    chk("R1 rd in reset", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd after reset", rd_data, 0);
    chk("R1 out after reset", pwm_out, 0);

    wr(32'hFFFF_FFFF);
    chk("R2 readback", rd_data, 32'hC000_FFFF);
    wr(32'h0000_0000);
    chk("R3 rest low", pwm_out, 0);
    wr(32'h4000_0000);
    chk("R3 rest high", pwm_out, 1);

    for (int i = 0; i < NV; i++) begin
      measure(VEC[i][0], VEC[i][1], $sformatf("vec%0d", i));
    end

    // R7 / R9 deferred update
    wr(32'h4000_0000);
    @(negedge clk);
    e0 = edges;
    wr(32'hC000_0240);
    wait_edges(e0 + 2);
    wr(32'hC000_02C0);
    wait_edges(e0 + 3);
    chk("R9 high not restarted", last_high, 384);
    wait_edges(e0 + 4);
    chk("R7 new low", last_low, 384);
    wait_edges(e0 + 5);
    chk("R7 new high", last_high, 128);

    // R3 disable while running
    wr(32'h4000_0100);
    chk("R3 disable to high", pwm_out, 1);
    wr(32'h0000_0100);
    chk("R3 disable to low", pwm_out, 0);

    // R6 low-time count 0
    wr(32'h8000_0100);
    repeat (2) @(negedge clk);
    zeros = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (pwm_out !== 1'b1) zeros++;
    end
    chk("R6 no low pulse", zeros, 0);

    // R4 divisor 0 means 256
    measure(0, 128, "div0");

    // R1 reset while running
    wr(32'hC000_0110);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run rd", rd_data, 0);
    chk("R1 mid-run out", pwm_out, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 stays idle", pwm_out, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule